// File: doc/BRIEF.md
# String Pointer Commit Unit

This unit serves the string-move family of a processor datapath. Each cycle it takes the current source index, destination index and count register values. It turns them into a source segment and offset and a destination segment and offset for the memory stage. It also works out how many elements the instruction covers: one when there is no repeat prefix, otherwise the count register.

The same inputs also produce the next index and count values. These are presented with write enables for the register file, and the enables rise only in a cycle where the instruction is committed with no exception pending. As a result, a faulting element leaves the architectural pointers untouched. The address size (16 or 32 bits) selects which register width is read and changed. The element size sets how far each pointer moves, and the direction input sets whether it moves up or down. The remaining count written back comes from the loop-control logic outside this unit.

Every output is registered and appears one clock after the inputs that produce it.

Top module: `str_ptr_commit`

## Requirements
- R1: The source segment output is the data segment code 3'd3 when no override is valid, and the override code when `seg_ovr_vld_i` is high.
- R2: The destination segment output is always the extra segment code 3'd0, whatever the override inputs are.
- R3: In 32-bit address mode the offsets are the full index inputs. In 16-bit mode they are the low 16 bits, zero-extended.
- R4: The pointer step is 1, 2 or 4 for `elem_sz_i` = 2'b00, 2'b01, 2'b10. The value 2'b11 also gives 4.
- R5: With `dir_dn_i` high the next index is the current index minus the step. With it low, the next index is the current index plus the step.
- R6: The effective count output is 1 without a repeat prefix. With a repeat prefix it is the full count input in 32-bit mode, or its low 16 bits zero-extended in 16-bit mode.
- R7: `cnt_we_o` rises only when a repeat prefix is present. The written value is `rem_cnt_i` in 32-bit mode; in 16-bit mode it is the low 16 bits of `rem_cnt_i` with the upper 16 bits of `cnt_i`.
- R8: In 16-bit mode the upper 16 bits of each next index equal those of the current index, and the low half wraps modulo 2^16.
- R9: `src_we_o` needs `has_src_i`, and `dst_we_o` needs `has_dst_i`. When both are set, both enables rise in the same cycle.
- R10: No write enable rises unless `commit_i` is high and `excp_i` is low.
- R11: Every output is registered with one cycle of latency. A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_idx_i | input | 32 | Current source index register |
| dst_idx_i | input | 32 | Current destination index register |
| cnt_i | input | 32 | Current count register |
| rem_cnt_i | input | 32 | Remaining count from loop control, to be written back |
| dir_dn_i | input | 1 | Direction: 1 = decrement |
| addr32_i | input | 1 | Address size: 1 = 32-bit, 0 = 16-bit |
| elem_sz_i | input | 2 | Element size code |
| rep_i | input | 1 | Repeat prefix present |
| seg_ovr_vld_i | input | 1 | Segment override present |
| seg_ovr_i | input | 3 | Override segment code |
| has_src_i | input | 1 | Instruction has a source string operand |
| has_dst_i | input | 1 | Instruction has a destination string operand |
| commit_i | input | 1 | Commit point of the instruction |
| excp_i | input | 1 | Exception pending |
| src_seg_o | output | 3 | Source segment code |
| src_off_o | output | 32 | Source offset |
| dst_seg_o | output | 3 | Destination segment code |
| dst_off_o | output | 32 | Destination offset |
| eff_cnt_o | output | 32 | Effective repetition count |
| src_idx_o | output | 32 | Next source index |
| src_we_o | output | 1 | Source index write enable |
| dst_idx_o | output | 32 | Next destination index |
| dst_we_o | output | 1 | Destination index write enable |
| cnt_o | output | 32 | Count write-back value |
| cnt_we_o | output | 1 | Count write enable |

## Verification
The directed patterns separate the cases that are easy to confuse:
- A byte increment in 16-bit mode against a word decrement from a low half of zero, where the wrap must leave the upper half alone.
- A dword decrement from zero in 32-bit mode, where the borrow must run through all 32 bits.
- A repeat prefix against no prefix, which tells a forced count of one from a count read from the register.
- An override against no override, which shows that only the source segment follows the override.
- Commit with an exception, commit without one, and source-only against destination-only instructions, which show that each enable is gated separately.

After these, a long run of random inputs mixes every combination and compares all outputs every clock.

// File: rtl/str_ptr_pkg.sv
package str_ptr_pkg;
  typedef logic [2:0] seg_t;
  localparam seg_t SEG_ES = 3'd0;
  localparam seg_t SEG_DS = 3'd3;

  function automatic logic [2:0] step_of(input logic [1:0] sz);
    case (sz)
      2'b00:   step_of = 3'd1;
      2'b01:   step_of = 3'd2;
      default: step_of = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/str_seg_sel.sv
module str_seg_sel
  import str_ptr_pkg::*;
#(
  parameter int IDX_W = 32
) (
  input  logic             addr32_i,
  input  logic             seg_ovr_vld_i,
  input  seg_t             seg_ovr_i,
  input  logic [IDX_W-1:0] src_idx_i,
  input  logic [IDX_W-1:0] dst_idx_i,
  output seg_t             src_seg,
  output seg_t             dst_seg,
  output logic [IDX_W-1:0] src_off,
  output logic [IDX_W-1:0] dst_off
);
  localparam int NW = IDX_W / 2;

  always_comb begin
    src_seg = seg_ovr_vld_i ? seg_ovr_i : SEG_DS;
    dst_seg = SEG_ES;
    src_off = addr32_i ? src_idx_i : {{(IDX_W-NW){1'b0}}, src_idx_i[NW-1:0]};
    dst_off = addr32_i ? dst_idx_i : {{(IDX_W-NW){1'b0}}, dst_idx_i[NW-1:0]};
  end
endmodule

// File: rtl/str_idx_step.sv
module str_idx_step #(
  parameter int IDX_W = 32
) (
  input  logic [IDX_W-1:0] cur_i,
  input  logic [2:0]       step_i,
  input  logic             dec_i,
  input  logic             wide_i,
  output logic [IDX_W-1:0] nxt_o
);
  localparam int NW = IDX_W / 2;

  logic [IDX_W-1:0] stp_w;
  logic [NW-1:0]    stp_n;
  logic [IDX_W-1:0] full_r;
  logic [NW-1:0]    half_r;

  always_comb begin
    stp_w  = {{(IDX_W-3){1'b0}}, step_i};
    stp_n  = {{(NW-3){1'b0}}, step_i};
    full_r = dec_i ? (cur_i - stp_w) : (cur_i + stp_w);
    half_r = dec_i ? (cur_i[NW-1:0] - stp_n) : (cur_i[NW-1:0] + stp_n);
    nxt_o  = wide_i ? full_r : {cur_i[IDX_W-1:NW], half_r};
  end
endmodule

// File: rtl/str_ptr_commit.sv
module str_ptr_commit
  import str_ptr_pkg::*;
#(
  parameter int IDX_W = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] src_idx_i,
  input  logic [31:0] dst_idx_i,
  input  logic [31:0] cnt_i,
  input  logic [31:0] rem_cnt_i,
  input  logic        dir_dn_i,
  input  logic        addr32_i,
  input  logic [1:0]  elem_sz_i,
  input  logic        rep_i,
  input  logic        seg_ovr_vld_i,
  input  logic [2:0]  seg_ovr_i,
  input  logic        has_src_i,
  input  logic        has_dst_i,
  input  logic        commit_i,
  input  logic        excp_i,
  output logic [2:0]  src_seg_o,
  output logic [31:0] src_off_o,
  output logic [2:0]  dst_seg_o,
  output logic [31:0] dst_off_o,
  output logic [31:0] eff_cnt_o,
  output logic [31:0] src_idx_o,
  output logic        src_we_o,
  output logic [31:0] dst_idx_o,
  output logic        dst_we_o,
  output logic [31:0] cnt_o,
  output logic        cnt_we_o
);
  localparam int NW = IDX_W / 2;

  seg_t             src_seg_c, dst_seg_c;
  logic [IDX_W-1:0] src_off_c, dst_off_c;
  logic [IDX_W-1:0] src_nxt_c, dst_nxt_c;
  logic [IDX_W-1:0] eff_c, cnt_c;
  logic [2:0]       step_c;
  logic             ok_c;

  str_seg_sel #(.IDX_W(IDX_W)) u_seg (
    .addr32_i(addr32_i), .seg_ovr_vld_i(seg_ovr_vld_i), .seg_ovr_i(seg_ovr_i),
    .src_idx_i(src_idx_i), .dst_idx_i(dst_idx_i),
    .src_seg(src_seg_c), .dst_seg(dst_seg_c),
    .src_off(src_off_c), .dst_off(dst_off_c)
  );

  assign step_c = step_of(elem_sz_i);

  str_idx_step #(.IDX_W(IDX_W)) u_src_step (
    .cur_i(src_idx_i), .step_i(step_c), .dec_i(dir_dn_i),
    .wide_i(addr32_i), .nxt_o(src_nxt_c)
  );

  str_idx_step #(.IDX_W(IDX_W)) u_dst_step (
    .cur_i(dst_idx_i), .step_i(step_c), .dec_i(dir_dn_i),
    .wide_i(addr32_i), .nxt_o(dst_nxt_c)
  );

  always_comb begin
    ok_c = commit_i && !excp_i;
    if (!rep_i)
      eff_c = {{(IDX_W-1){1'b0}}, 1'b1};
    else if (addr32_i)
      eff_c = cnt_i;
    else
      eff_c = {{(IDX_W-NW){1'b0}}, cnt_i[NW-1:0]};
    cnt_c = addr32_i ? rem_cnt_i : {cnt_i[IDX_W-1:NW], rem_cnt_i[NW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_seg_o <= '0;
      dst_seg_o <= '0;
      src_off_o <= '0;
      dst_off_o <= '0;
      eff_cnt_o <= '0;
      src_idx_o <= '0;
      dst_idx_o <= '0;
      cnt_o     <= '0;
      src_we_o  <= 1'b0;
      dst_we_o  <= 1'b0;
      cnt_we_o  <= 1'b0;
    end else begin
      src_seg_o <= src_seg_c;
      dst_seg_o <= dst_seg_c;
      src_off_o <= src_off_c;
      dst_off_o <= dst_off_c;
      eff_cnt_o <= eff_c;
      src_idx_o <= src_nxt_c;
      dst_idx_o <= dst_nxt_c;
      cnt_o     <= cnt_c;
      src_we_o  <= ok_c && has_src_i;
      dst_we_o  <= ok_c && has_dst_i;
      cnt_we_o  <= ok_c && rep_i;
    end
  end

  // R10: a pending exception blocks every write enable in the following cycle
  p_excp_blocks_r10: assert property (@(posedge clk) disable iff (rst)
    excp_i |=> !(src_we_o || dst_we_o || cnt_we_o));

  // R7: no repeat prefix, no count write
  p_cnt_needs_rep_r7: assert property (@(posedge clk) disable iff (rst)
    !rep_i |=> !cnt_we_o);

  // R9: an enable never rises for an absent operand
  p_src_needs_op_r9: assert property (@(posedge clk) disable iff (rst)
    !has_src_i |=> !src_we_o);
  p_dst_needs_op_r9: assert property (@(posedge clk) disable iff (rst)
    !has_dst_i |=> !dst_we_o);

  // R8: 16-bit mode keeps the upper half of both indexes
  p_upper_kept_r8: assert property (@(posedge clk) disable iff (rst)
    !addr32_i |=> (src_idx_o[31:16] == $past(src_idx_i[31:16]))
               && (dst_idx_o[31:16] == $past(dst_idx_i[31:16])));

  // R2: destination segment ignores the override
  p_dst_es_r2: assert property (@(posedge clk) disable iff (rst)
    seg_ovr_vld_i |=> dst_seg_o == SEG_ES);

  // R5: a written index always differs from the one it replaces
  p_moves_r5: assert property (@(posedge clk) disable iff (rst)
    (commit_i && has_src_i) |=> src_idx_o != $past(src_idx_i));
endmodule

// File: tb/str_ptr_commit_bench.sv
`timescale 1ns/1ps
module str_ptr_commit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [31:0] src_idx_i = '0, dst_idx_i = '0, cnt_i = '0, rem_cnt_i = '0;
  logic dir_dn_i = 0, addr32_i = 0, rep_i = 0, seg_ovr_vld_i = 0;
  logic has_src_i = 0, has_dst_i = 0, commit_i = 0, excp_i = 0;
  logic [1:0] elem_sz_i = '0;
  logic [2:0] seg_ovr_i = '0;
  logic [2:0]  src_seg_o, dst_seg_o;
  logic [31:0] src_off_o, dst_off_o, eff_cnt_o, src_idx_o, dst_idx_o, cnt_o;
  logic src_we_o, dst_we_o, cnt_we_o;

  str_ptr_commit u_str_ptr_commit (.*);

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] cur);
    int st;
    logic [15:0] lo;
    st = (elem_sz_i == 2'b00) ? 1 : (elem_sz_i == 2'b01) ? 2 : 4;
    if (addr32_i) return dir_dn_i ? cur - st : cur + st;
    lo = dir_dn_i ? cur[15:0] - 16'(st) : cur[15:0] + 16'(st);
    return {cur[31:16], lo};
  endfunction

  // Apply current inputs, clock once, compare every output against the model.
  task automatic step();
    logic [2:0] e_ss;
    logic [31:0] e_so, e_do, e_eff, e_si, e_di, e_cnt;
    logic ok;
    e_ss  = seg_ovr_vld_i ? seg_ovr_i : 3'd3;
    e_so  = addr32_i ? src_idx_i : {16'h0, src_idx_i[15:0]};
    e_do  = addr32_i ? dst_idx_i : {16'h0, dst_idx_i[15:0]};
    e_eff = !rep_i ? 32'd1 : (addr32_i ? cnt_i : {16'h0, cnt_i[15:0]});
    e_si  = nxt(src_idx_i);
    e_di  = nxt(dst_idx_i);
    e_cnt = addr32_i ? rem_cnt_i : {cnt_i[31:16], rem_cnt_i[15:0]};
    ok    = commit_i && !excp_i;
    @(posedge clk);
    #1;
    vectors++;
    chk("R1 src_seg", {29'h0, src_seg_o}, {29'h0, e_ss});
    chk("R2 dst_seg", {29'h0, dst_seg_o}, 32'd0);
    chk("R3 src_off", src_off_o, e_so);
    chk("R3 dst_off", dst_off_o, e_do);
    chk("R6 eff_cnt", eff_cnt_o, e_eff);
    chk("R4/R5/R8 src_idx", src_idx_o, e_si);
    chk("R4/R5/R8 dst_idx", dst_idx_o, e_di);
    chk("R7 cnt", cnt_o, e_cnt);
    chk("R9/R10 src_we", {31'h0, src_we_o}, {31'h0, ok && has_src_i});
    chk("R9/R10 dst_we", {31'h0, dst_we_o}, {31'h0, ok && has_dst_i});
    chk("R7/R10 cnt_we", {31'h0, cnt_we_o}, {31'h0, ok && rep_i});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R11: reset clears every output
    vectors++;
    chk("R11 reset", {src_off_o | dst_off_o | eff_cnt_o | src_idx_o | dst_idx_o | cnt_o},
        32'd0);
    chk("R11 reset we", {29'h0, src_we_o, dst_we_o, cnt_we_o}, 32'd0);
    rst = 1'b0;

    // R4 byte increment, 16-bit, both operands
    src_idx_i = 32'hABCD_0010; dst_idx_i = 32'h1111_FFFF; elem_sz_i = 2'b00;
    has_src_i = 1; has_dst_i = 1; commit_i = 1; step();
    // R8 word decrement wrapping the low half
    src_idx_i = 32'h1234_0000; dir_dn_i = 1; elem_sz_i = 2'b01; step();
    // R5 dword decrement from zero in 32-bit mode
    addr32_i = 1; src_idx_i = 32'h0; dst_idx_i = 32'h8000_0000; elem_sz_i = 2'b10; step();
    elem_sz_i = 2'b11; dir_dn_i = 0; step();
    // R6/R7 repeat prefix against none
    cnt_i = 32'h0005_0007; rem_cnt_i = 32'h0000_0006; rep_i = 1; step();
    addr32_i = 0; rem_cnt_i = 32'hFFFF_0003; step();
    rep_i = 0; step();
    // R1/R2 override
    seg_ovr_vld_i = 1; seg_ovr_i = 3'd5; step();
    seg_ovr_i = 3'd2; step();
    // R10 exception and missing commit
    rep_i = 1; excp_i = 1; step();
    excp_i = 0; commit_i = 0; step();
    // R9 source only, destination only
    commit_i = 1; has_dst_i = 0; step();
    has_src_i = 0; has_dst_i = 1; step();

    for (int k = 0; k < 400; k++) begin
      src_idx_i = $urandom; dst_idx_i = $urandom; cnt_i = $urandom; rem_cnt_i = $urandom;
      {dir_dn_i, addr32_i, rep_i, seg_ovr_vld_i} = 4'($urandom);
      {has_src_i, has_dst_i, commit_i, excp_i} = 4'($urandom);
      elem_sz_i = 2'($urandom); seg_ovr_i = 3'($urandom);
      if (k % 7 == 0) src_idx_i[15:0] = dir_dn_i ? 16'h0001 : 16'hFFFE;
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule